// File: doc/BRIEF.md
# Paged Direct-Page Window and Flash Control Registers

This block sits between the CPU of a small 8-bit microcontroller and its 14-bit memory map. It holds two registers. The page register selects which 64-byte block of the address space is seen through a fixed 64-byte window at CPU addresses 0x00C0 to 0x00FF. Any access in that window is redirected to the selected block. All other addresses reach the memory map unchanged. The address translation is purely combinational, so it applies in the same cycle as the access.

The flash control register drives three operation-select lines for the flash array: program, mass erase and high-voltage enable. Hardware interlocks protect these lines, and no sequence of CPU writes can get past them. Program and mass erase are never active together. High voltage needs an operation selected. While the security input is high, the program bit is frozen.

Top module: `pgwin_flash_regs`

## Requirements
- R1: For a CPU address in 0x00C0..0x00FF, `mem_addr` equals {page register, `bus_addr[5:0]`} in the same cycle; with page 0x08, 0x00C0 maps to 0x0200 and 0x00FF maps to 0x023F.
- R2: For a CPU address outside 0x00C0..0x00FF, `mem_addr` equals `bus_addr`.
- R3: The page register resets to 0x08. A write at address 0x0010 loads `bus_wdata` on that clock edge, and a read at 0x0010 returns the stored value.
- R4: After reset, the flash control register reads 0x00 and `flash_prog`, `flash_erase` and `flash_hv` are 0.
- R5: The flash control register has HV at bit 3, ERASE at bit 2 and PROG at bit 0, and sits at address 0x0010+1 = 0x0011. PROG and ERASE are never both 1. A write leaves both bits unchanged in three cases: it requests both; it raises PROG while ERASE is 1; it raises ERASE while PROG is 1.
- R6: HV becomes 1 only if bit 3 of the write is 1 and, after that write, PROG or ERASE is 1. Otherwise HV becomes 0, so a request for HV with no operation selected is ignored.
- R7: While `secure` is 1, a flash control write leaves PROG unchanged, whether it would set or clear it.
- R8: A write that leaves PROG and ERASE both 0 also clears HV on the same edge.
- R9: A flash control read returns 0 in bits 7..4 and bit 1. With `bus_rd` low, `bus_rdata` is 0. A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 14 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| secure | input | 1 | Security engaged; freezes PROG |
| mem_addr | output | 14 | Translated memory address |
| flash_prog | output | 1 | Program operation selected |
| flash_erase | output | 1 | Mass erase operation selected |
| flash_hv | output | 1 | High voltage enabled to the array |

## Verification
A corrupted page register appears on `mem_addr` in the same cycle that any window address is presented. The bench therefore compares both window edges after each of the 256 page values. A wrong flash interlock state shows on the three control outputs, and on the register read-back, one edge after the write that caused it. Every write nibble is applied from every legal starting state, with security both off and on, so any faulty transition is seen on the edge that follows the offending write.

// File: rtl/pgwin_pkg.sv
// Package: shared types and bit positions for the paged window and
// flash control unit. Assumes an 8-bit data bus.
package pgwin_pkg;
    // Bit positions of the flash control fields in the register image.
    localparam int FC_PROG_BIT  = 0;
    localparam int FC_ERASE_BIT = 2;
    localparam int FC_HV_BIT    = 3;

    // Stored flash control state.
    typedef struct packed {
        logic hv;
        logic erase;
        logic prog;
    } fctl_t;
endpackage

// File: rtl/pgwin_page_reg.sv
// Page register and window translation.
// Holds the page select value. Any CPU address whose upper bits equal
// WIN_BLK is redirected to {page, low offset}; other addresses pass
// through unchanged. Assumes DATA_W >= ADDR_W - BLK_W.
module pgwin_page_reg #(
    parameter int ADDR_W = 14,
    parameter int BLK_W  = 6,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-BLK_W-1:0] WIN_BLK  = 8'h03,
    parameter logic [ADDR_W-BLK_W-1:0] PAGE_RST = 8'h08
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [ADDR_W-1:0]         cpu_addr,
    output logic [ADDR_W-BLK_W-1:0]   page_q,
    output logic [ADDR_W-1:0]         mem_addr
);
    localparam int PAGE_W = ADDR_W - BLK_W;

    logic in_win;

    // Page register update: reset value, else load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= PAGE_RST;
        else if (wr_en)
            page_q <= wdata[PAGE_W-1:0];
    end

    // Window detection and address translation.
    always_comb begin
        in_win = (cpu_addr[ADDR_W-1:BLK_W] == WIN_BLK);
        if (in_win)
            mem_addr = {page_q, cpu_addr[BLK_W-1:0]};
        else
            mem_addr = cpu_addr;
    end

    // A write must be visible in the page register on the next cycle.
    assert_page_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rst_n) |=> (page_q == $past(wdata[PAGE_W-1:0])));
endmodule

// File: rtl/pgwin_flash_ctl.sv
// Flash control register with hardware interlocks.
// PROG and ERASE are mutually exclusive. HV needs one of them. Security
// freezes PROG. Assumes only the three field bits of the write are given.
module pgwin_flash_ctl
    import pgwin_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_hv,
    input  logic  wr_erase,
    input  logic  wr_prog,
    input  logic  secure,
    output fctl_t st_q
);
    fctl_t nxt;
    logic  req_prog;
    logic  req_erase;
    logic  reject;

    // Next state: apply security, then the exclusion check, then the HV gate.
    always_comb begin
        req_prog  = secure ? st_q.prog : wr_prog;
        req_erase = wr_erase;
        reject    = (req_prog & req_erase)
                  | (req_prog  & ~st_q.prog  & st_q.erase)
                  | (req_erase & ~st_q.erase & st_q.prog);
        nxt = st_q;
        if (wr_en) begin
            nxt.prog  = reject ? st_q.prog  : req_prog;
            nxt.erase = reject ? st_q.erase : req_erase;
            nxt.hv    = wr_hv & (nxt.prog | nxt.erase);
        end
    end

    // State register: all fields clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= nxt;
    end

    assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.prog && st_q.erase));

    assert_hv_needs_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hv |-> (st_q.prog || st_q.erase));

    assert_secure_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (secure && rst_n) |=> (st_q.prog == $past(st_q.prog)));
endmodule

// File: rtl/pgwin_rd_mux.sv
// Read data selection. Returns the addressed register image while the
// read strobe is high; returns zero otherwise and for unknown addresses.
module pgwin_rd_mux
    import pgwin_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic              rd,
    input  logic              sel_page,
    input  logic              sel_fctl,
    input  logic [PAGE_W-1:0] page,
    input  fctl_t             fctl,
    output logic [DATA_W-1:0] rdata
);
    // Assemble the addressed register; reserved bits stay zero.
    always_comb begin
        rdata = '0;
        if (rd && sel_page) begin
            rdata[PAGE_W-1:0] = page;
        end else if (rd && sel_fctl) begin
            rdata[FC_HV_BIT]    = fctl.hv;
            rdata[FC_ERASE_BIT] = fctl.erase;
            rdata[FC_PROG_BIT]  = fctl.prog;
        end
    end
endmodule

// File: rtl/pgwin_flash_regs.sv
// Top: paged direct-page window plus flash control register.
// Decodes the two register addresses, instantiates the page register,
// the flash control and the read mux. Assumes single-cycle strobes and
// register addresses outside the window.
module pgwin_flash_regs
    import pgwin_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BLK_W  = 6,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PAGE_ADDR = 14'h0010,
    parameter logic [ADDR_W-1:0] FCTL_ADDR = 14'h0011,
    parameter logic [ADDR_W-BLK_W-1:0] WIN_BLK  = 8'h03,
    parameter logic [ADDR_W-BLK_W-1:0] PAGE_RST = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              secure,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              flash_prog,
    output logic              flash_erase,
    output logic              flash_hv
);
    localparam int PAGE_W = ADDR_W - BLK_W;

    logic              hit_page;
    logic              hit_fctl;
    logic [PAGE_W-1:0] page_q;
    fctl_t             fctl_q;

    // Register address decode.
    always_comb begin
        hit_page = (bus_addr == PAGE_ADDR);
        hit_fctl = (bus_addr == FCTL_ADDR);
    end

    pgwin_page_reg #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W),
        .WIN_BLK(WIN_BLK), .PAGE_RST(PAGE_RST)
    ) page_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr && hit_page),
        .wdata(bus_wdata),
        .cpu_addr(bus_addr),
        .page_q(page_q),
        .mem_addr(mem_addr)
    );

    pgwin_flash_ctl fctl_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr && hit_fctl),
        .wr_hv(bus_wdata[FC_HV_BIT]),
        .wr_erase(bus_wdata[FC_ERASE_BIT]),
        .wr_prog(bus_wdata[FC_PROG_BIT]),
        .secure(secure),
        .st_q(fctl_q)
    );

    pgwin_rd_mux #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) rmux_i (
        .rd(bus_rd), .sel_page(hit_page), .sel_fctl(hit_fctl),
        .page(page_q), .fctl(fctl_q), .rdata(bus_rdata)
    );

    // Drive the flash operation lines from the stored state.
    always_comb begin
        flash_prog  = fctl_q.prog;
        flash_erase = fctl_q.erase;
        flash_hv    = fctl_q.hv;
    end

    assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/pgwin_flash_regs_tb_top.sv
`timescale 1ns/1ps
module pgwin_flash_regs_tb_top;
    localparam logic [13:0] PAGE_A = 14'h0010;
    localparam logic [13:0] FCTL_A = 14'h0011;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr, bus_rd, secure;
    logic [7:0]  bus_rdata;
    logic [13:0] mem_addr;
    logic        flash_prog, flash_erase, flash_hv;

    always #10 clk = ~clk;

    pgwin_flash_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .secure(secure), .mem_addr(mem_addr), .flash_prog(flash_prog),
        .flash_erase(flash_erase), .flash_hv(flash_hv)
    );

    typedef struct {
        string       tag;
        int          sel;   // 0 mem_addr, 1 rdata, 2 {hv,erase,prog}
        logic [15:0] exp;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;

    logic [7:0] m_page;
    logic [2:0] m_fl;   // {hv, erase, prog}

    // Monitor: pops expected items and compares with the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [15:0] act;
                it = sb_q.pop_front();
                case (it.sel)
                    0:       act = {2'b00, mem_addr};
                    1:       act = {8'h00, bus_rdata};
                    default: act = {13'b0, flash_hv, flash_erase, flash_prog};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push_exp(string tag, int sel, logic [15:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
        ->chk_ev;
        #1;
    endtask

    task automatic bus_write(logic [13:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 14'h0000;
    endtask

    task automatic read_chk(logic [13:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        push_exp(tag, 1, {8'h00, exp});
        bus_rd = 1'b0;
    endtask

    task automatic addr_chk(logic [13:0] a, logic [13:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        push_exp(tag, 0, {2'b00, exp});
    endtask

    // Expected flash state after a write, derived from R5..R8.
    function automatic logic [2:0] fl_model(logic [2:0] cur, logic [7:0] d, logic sec);
        logic p, m, pr, mr;
        pr = sec ? cur[0] : d[0];
        mr = d[2];
        if (pr && mr)                       begin p = cur[0]; m = cur[1]; end
        else if (pr && !cur[0] && cur[1])   begin p = cur[0]; m = cur[1]; end
        else if (mr && !cur[1] && cur[0])   begin p = cur[0]; m = cur[1]; end
        else                                begin p = pr;     m = mr;     end
        return {d[3] && (p || m), m, p};
    endfunction

    task automatic fl_write(logic [7:0] d);
        m_fl = fl_model(m_fl, d, secure);
        bus_write(FCTL_A, d);
    endtask

    function automatic logic [7:0] fl_image(logic [2:0] f);
        return {4'b0000, f[2], f[1], 1'b0, f[0]};
    endfunction

    // Watchdog: a hung run is a failed check.
    initial begin
        #(20 * 100000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Driver: stimulus sequence.
    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0;
        bus_wr = 1'b0; bus_rd = 1'b0; secure = 1'b0;
        m_page = 8'h08; m_fl = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state.
        read_chk(PAGE_A, 8'h08, "R3 page reset");
        read_chk(FCTL_A, 8'h00, "R4 flash reg reset");
        @(negedge clk); #1;
        push_exp("R4 flash outputs reset", 2, 16'h0000);
        addr_chk(14'h00C0, 14'h0200, "R1 window low edge page 08");
        addr_chk(14'h00FF, 14'h023F, "R1 window high edge page 08");
        @(negedge clk); bus_rd = 1'b0; bus_addr = PAGE_A; #1;
        push_exp("R9 idle rdata", 1, 16'h0000);

        // Every page value at both window edges.
        for (int p = 0; p < 256; p++) begin
            m_page = p[7:0];
            bus_write(PAGE_A, m_page);
            addr_chk(14'h00C0, {m_page, 6'h00}, "R1 window low edge");
            addr_chk(14'h00FF, {m_page, 6'h3F}, "R1 window high edge");
            if (p % 37 == 0) read_chk(PAGE_A, m_page, "R3 page read back");
        end
        addr_chk(14'h00BF, 14'h00BF, "R2 below window");
        addr_chk(14'h0100, 14'h0100, "R2 above window");
        addr_chk(14'h3FFF, 14'h3FFF, "R2 top of map");
        addr_chk(14'h0000, 14'h0000, "R2 bottom of map");

        // Writes elsewhere change neither register.
        bus_write(14'h0012, 8'hFF);
        bus_write(14'h00C0, 8'h5A);
        read_chk(PAGE_A, m_page, "R9 page untouched by other writes");
        read_chk(FCTL_A, 8'h00, "R9 flash untouched by other writes");

        // Explicit HV-clear case.
        fl_write(8'h04); fl_write(8'h0C);
        @(negedge clk); #1; push_exp("R6 hv with erase", 2, 16'h0006);
        fl_write(8'h08);
        @(negedge clk); #1; push_exp("R8 hv cleared with pair", 2, 16'h0000);

        // Every write nibble from every legal state, security off and on.
        for (int s = 0; s < 2; s++) begin
            for (int st = 0; st < 5; st++) begin
                for (int d = 0; d < 16; d++) begin
                    secure = 1'b0;
                    fl_write(8'h00);
                    case (st)
                        1: fl_write(8'h01);
                        2: fl_write(8'h04);
                        3: begin fl_write(8'h01); fl_write(8'h09); end
                        4: begin fl_write(8'h04); fl_write(8'h0C); end
                        default: ;
                    endcase
                    secure = s[0];
                    fl_write({4'h0, d[3:0]} | (d == 15 ? 8'hF0 : 8'h00));
                    #1;
                    push_exp("R5 R6 R7 R8 interlock outputs", 2, {13'b0, m_fl});
                    read_chk(FCTL_A, fl_image(m_fl), "R9 flash read image");
                end
            end
        end
        secure = 1'b0;

        done = 1'b1;
        #1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule